// File: doc/BRIEF.md
# JTAG Debug Bus Bridge

This block is a JTAG test access port that gives an external debugger a way into two on-chip buses: a debug-module bus with a narrow address and 64-bit data, and a Wishbone master with 64-bit address and data. The debugger picks a data register by loading an instruction code. It then shifts an address, a read request or a write-then-read request through that register. The port also holds a fixed 32-bit identification value, and it falls back to a single-bit bypass stage for any instruction code it does not use.

Each bus has three instructions: one to set the address, one for a plain read, and one for a combined write that hands back the register's old contents in the same scan. Bus cycles run on the system clock. Requests cross from TCK through a toggle handshake with two-flop synchronisers, and completions cross back the same way. A read result is fetched ahead of time into a shadow register, so that Capture-DR can load it with no wait. The prefetch happens when the address is updated, after every plain read scan, and after every write. The shadow then holds the value that was written.

The debugger must leave a few Run-Test/Idle cycles after each Update-DR so that the bus access can finish. A new request that arrives while the previous one is still in flight is dropped.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: Five consecutive TCK cycles with TMS high reach Test-Logic-Reset from any state and select the identification instruction (code 1). A following 32-bit DR scan shifts out 0x000018FF, LSB first.
- R2: During an IR scan (4-bit IR) the captured pattern 4'b0001 is shifted out LSB first.
- R3: Any code other than 1, 5-10 selects a one-bit bypass stage that captures 0. Each TDI bit reappears on TDO one shift later.
- R4: Code 8 selects the 8-bit debug-bus address register. Capture returns the current address, and Update-DR loads the shifted value.
- R5: Code 9 is a 64-bit read. The scan returns the contents of the debug-bus register at the current address.
- R6: Code 10 is a 64-bit write-then-read. The scan returns the register's previous contents, and Update-DR issues exactly one write of the shifted value to the current address. A later read returns the new value.
- R7: Codes 5, 6 and 7 do the same for the Wishbone port, with a 64-bit address register and 64-bit data.
- R8: A bus request (dmi_req, or wb_cyc with wb_stb) stays asserted, with address, write flag and write data held, until the cycle in which the target acknowledges. It drops in the next clock.
- R9: TDO and tdo_oe change only on the falling edge of TCK. tdo_oe is high only while in Shift-IR or Shift-DR.
- R10: While rst is high, no bus request is driven, tdo_oe is low and the TAP goes to Test-Logic-Reset with the identification instruction selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus side |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Test data in, sampled on rising TCK |
| tdo | output | 1 | Test data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable, high in shift states |
| dmi_req | output | 1 | Debug-bus request, held until acknowledge |
| dmi_we | output | 1 | Debug-bus write flag |
| dmi_addr | output | DMI_AW (8) | Debug-bus address |
| dmi_wdata | output | DMI_DW (64) | Debug-bus write data |
| dmi_rdata | input | DMI_DW (64) | Debug-bus read data, valid with dmi_ack |
| dmi_ack | input | 1 | Debug-bus acknowledge |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | WB_AW (64) | Wishbone address |
| wb_dat_o | output | WB_DW (64) | Wishbone write data |
| wb_dat_i | input | WB_DW (64) | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
Both bus paths are driven through the same sequence: set the address, read, write-then-read, then read again. This separates the returned old value from the newly stored one, and it shows whether the write reached the right address exactly once. Moving the address and reading back the address register itself shows whether the prefetch follows the address. A non-trivial bit pattern through bypass tells a correct one-cycle delay from a pass-through or a stuck bit. The identification value is read three ways (straight after reset, by explicit instruction, and after a TMS-driven reset from a different instruction), which separates the reset-selection paths.

// File: rtl/jdb_pkg.sv
package jdb_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  // instruction codes
  localparam int IC_IDCODE  = 1;
  localparam int IC_WB_ADDR = 5;
  localparam int IC_WB_RD   = 6;
  localparam int IC_WB_WR   = 7;
  localparam int IC_DM_ADDR = 8;
  localparam int IC_DM_RD   = 9;
  localparam int IC_DM_WR   = 10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/jdb_tap_fsm.sv
module jdb_tap_fsm
  import jdb_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nxt = tms ? S_SEL_DR : S_RTI;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= S_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/jdb_bus_port.sv
// One bus master fed from the TCK domain via a toggle handshake.
module jdb_bus_port #(
  parameter int AW = 8,
  parameter int DW = 64
) (
  input  logic          tck,
  input  logic          clk,
  input  logic          rst,
  // TCK side
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          busy,
  output logic [DW-1:0] result,
  // system side
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack
);

  logic          req_t, ack_m, ack_s, ack_seen;
  logic          op_we;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic          req_m, req_s, req_seen, ack_t;
  logic [DW-1:0] rdata_q;

  assign busy = (req_t != ack_seen);

  // TCK domain: launch and completion
  always_ff @(posedge tck) begin
    if (rst) begin
      req_t    <= 1'b0;
      ack_m    <= 1'b0;
      ack_s    <= 1'b0;
      ack_seen <= 1'b0;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      result   <= '0;
    end else begin
      ack_m <= ack_t;
      ack_s <= ack_m;
      if (ack_s != ack_seen) begin
        ack_seen <= ack_s;
        result   <= rdata_q;
      end
      if (go && !busy) begin
        req_t    <= ~req_t;
        op_we    <= go_we;
        op_addr  <= go_addr;
        op_wdata <= go_wdata;
      end
    end
  end

  // system domain: bus cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      req_m     <= 1'b0;
      req_s     <= 1'b0;
      req_seen  <= 1'b0;
      ack_t     <= 1'b0;
      rdata_q   <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      req_m <= req_t;
      req_s <= req_m;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req <= 1'b0;
          rdata_q <= bus_we ? bus_wdata : bus_rdata;
          ack_t   <= ~ack_t;
        end
      end else if (req_s != req_seen) begin
        req_seen  <= req_s;
        bus_req   <= 1'b1;
        bus_we    <= op_we;
        bus_addr  <= op_addr;
        bus_wdata <= op_wdata;
      end
    end
  end

endmodule

// File: rtl/jtag_dbg_bridge.sv
module jtag_dbg_bridge
  import jdb_pkg::*;
#(
  parameter int          IR_W     = 4,
  parameter int          DMI_AW   = 8,
  parameter int          DMI_DW   = 64,
  parameter int          WB_AW    = 64,
  parameter int          WB_DW    = 64,
  parameter logic [31:0] ID_VALUE = 32'h0000_18FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              dmi_req,
  output logic              dmi_we,
  output logic [DMI_AW-1:0] dmi_addr,
  output logic [DMI_DW-1:0] dmi_wdata,
  input  logic [DMI_DW-1:0] dmi_rdata,
  input  logic              dmi_ack,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [WB_AW-1:0]  wb_adr,
  output logic [WB_DW-1:0]  wb_dat_o,
  input  logic [WB_DW-1:0]  wb_dat_i,
  input  logic              wb_ack
);

  localparam int SR_W  = imax(imax(imax(DMI_AW, DMI_DW), imax(WB_AW, WB_DW)), 32);
  localparam int LEN_W = $clog2(SR_W + 1);

  localparam logic [IR_W-1:0] I_ID  = IR_W'(IC_IDCODE);
  localparam logic [IR_W-1:0] I_WA  = IR_W'(IC_WB_ADDR);
  localparam logic [IR_W-1:0] I_WR  = IR_W'(IC_WB_RD);
  localparam logic [IR_W-1:0] I_WW  = IR_W'(IC_WB_WR);
  localparam logic [IR_W-1:0] I_DA  = IR_W'(IC_DM_ADDR);
  localparam logic [IR_W-1:0] I_DR  = IR_W'(IC_DM_RD);
  localparam logic [IR_W-1:0] I_DW  = IR_W'(IC_DM_WR);

  tap_state_e        st;
  logic [IR_W-1:0]   ir_q, ir_sr;
  logic [SR_W-1:0]   dr_sr, sr_nx, cap_val;
  logic [LEN_W-1:0]  dr_len;
  logic [DMI_AW-1:0] dm_addr_q;
  logic [WB_AW-1:0]  wb_addr_q;
  logic [DMI_DW-1:0] dm_result;
  logic [WB_DW-1:0]  wb_result;
  logic              dm_busy, wb_busy;
  logic              dm_go, wb_go;
  logic              wb_req;

  jdb_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (st)
  );

  // selected data register length
  always_comb begin
    case (ir_q)
      I_ID:       dr_len = LEN_W'(32);
      I_DA:       dr_len = LEN_W'(DMI_AW);
      I_DR, I_DW: dr_len = LEN_W'(DMI_DW);
      I_WA:       dr_len = LEN_W'(WB_AW);
      I_WR, I_WW: dr_len = LEN_W'(WB_DW);
      default:    dr_len = LEN_W'(1);
    endcase
  end

  // value loaded at Capture-DR
  always_comb begin
    case (ir_q)
      I_ID:       cap_val = SR_W'(ID_VALUE);
      I_DA:       cap_val = SR_W'(dm_addr_q);
      I_DR, I_DW: cap_val = SR_W'(dm_result);
      I_WA:       cap_val = SR_W'(wb_addr_q);
      I_WR, I_WW: cap_val = SR_W'(wb_result);
      default:    cap_val = '0;
    endcase
  end

  // shift right, TDI enters at the top of the selected length
  always_comb begin
    sr_nx = {dr_sr[SR_W-1], dr_sr[SR_W-1:1]};
    for (int i = 0; i < SR_W; i++) begin
      if (LEN_W'(i + 1) == dr_len) sr_nx[i] = tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_q      <= I_ID;
      ir_sr     <= '0;
      dr_sr     <= '0;
      dm_addr_q <= '0;
      wb_addr_q <= '0;
    end else begin
      case (st)
        S_TLR:    ir_q  <= I_ID;
        S_CAP_IR: ir_sr <= IR_W'(1);
        S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        S_UPD_IR: ir_q  <= ir_sr;
        S_CAP_DR: dr_sr <= cap_val;
        S_SH_DR:  dr_sr <= sr_nx;
        S_UPD_DR: begin
          if (ir_q == I_DA) dm_addr_q <= dr_sr[DMI_AW-1:0];
          if (ir_q == I_WA) wb_addr_q <= dr_sr[WB_AW-1:0];
        end
        default: ;
      endcase
    end
  end

  // TDO launched on the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == S_SH_DR) || (st == S_SH_IR);
      if (st == S_SH_IR)      tdo <= ir_sr[0];
      else if (st == S_SH_DR) tdo <= dr_sr[0];
      else                    tdo <= 1'b0;
    end
  end

  assign dm_go = (st == S_UPD_DR) && ((ir_q == I_DA) || (ir_q == I_DR) || (ir_q == I_DW));
  assign wb_go = (st == S_UPD_DR) && ((ir_q == I_WA) || (ir_q == I_WR) || (ir_q == I_WW));

  jdb_bus_port #(.AW(DMI_AW), .DW(DMI_DW)) u_dm (
    .tck       (tck),
    .clk       (clk),
    .rst       (rst),
    .go        (dm_go),
    .go_we     (ir_q == I_DW),
    .go_addr   ((ir_q == I_DA) ? dr_sr[DMI_AW-1:0] : dm_addr_q),
    .go_wdata  (dr_sr[DMI_DW-1:0]),
    .busy      (dm_busy),
    .result    (dm_result),
    .bus_req   (dmi_req),
    .bus_we    (dmi_we),
    .bus_addr  (dmi_addr),
    .bus_wdata (dmi_wdata),
    .bus_rdata (dmi_rdata),
    .bus_ack   (dmi_ack)
  );

  jdb_bus_port #(.AW(WB_AW), .DW(WB_DW)) u_wb (
    .tck       (tck),
    .clk       (clk),
    .rst       (rst),
    .go        (wb_go),
    .go_we     (ir_q == I_WW),
    .go_addr   ((ir_q == I_WA) ? dr_sr[WB_AW-1:0] : wb_addr_q),
    .go_wdata  (dr_sr[WB_DW-1:0]),
    .busy      (wb_busy),
    .result    (wb_result),
    .bus_req   (wb_req),
    .bus_we    (wb_we),
    .bus_addr  (wb_adr),
    .bus_wdata (wb_dat_o),
    .bus_rdata (wb_dat_i),
    .bus_ack   (wb_ack)
  );

  assign wb_cyc = wb_req;
  assign wb_stb = wb_req;

  logic unused_busy;
  assign unused_busy = dm_busy ^ wb_busy;

endmodule

// File: rtl/jtag_dbg_bridge_chk.sv
module jtag_dbg_bridge_chk #(
  parameter int DAW = 8,
  parameter int DDW = 64,
  parameter int WAW = 64,
  parameter int WDW = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           tck,
  input logic           tdo_oe,
  input logic           dmi_req,
  input logic           dmi_we,
  input logic [DAW-1:0] dmi_addr,
  input logic [DDW-1:0] dmi_wdata,
  input logic           dmi_ack,
  input logic           wb_cyc,
  input logic           wb_we,
  input logic [WAW-1:0] wb_adr,
  input logic [WDW-1:0] wb_dat_o,
  input logic           wb_ack
);

  // R8
  dmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dmi_req && !dmi_ack |=> dmi_req);
  // R8
  dmi_stable_chk: assert property (@(posedge clk) disable iff (rst)
    dmi_req && !dmi_ack |=> $stable(dmi_addr) && $stable(dmi_we) && $stable(dmi_wdata));
  // R8
  dmi_release_chk: assert property (@(posedge clk) disable iff (rst)
    dmi_req && dmi_ack |=> !dmi_req);
  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wb_cyc && !wb_ack |=> wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o));
  // R8
  wb_release_chk: assert property (@(posedge clk) disable iff (rst)
    wb_cyc && wb_ack |=> !wb_cyc);
  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !dmi_req && !wb_cyc);
  // R10
  rst_oe_chk: assert property (@(posedge tck)
    rst |=> !tdo_oe);

endmodule

bind jtag_dbg_bridge jtag_dbg_bridge_chk #(
  .DAW(DMI_AW), .DDW(DMI_DW), .WAW(WB_AW), .WDW(WB_DW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tck       (tck),
  .tdo_oe    (tdo_oe),
  .dmi_req   (dmi_req),
  .dmi_we    (dmi_we),
  .dmi_addr  (dmi_addr),
  .dmi_wdata (dmi_wdata),
  .dmi_ack   (dmi_ack),
  .wb_cyc    (wb_cyc),
  .wb_we     (wb_we),
  .wb_adr    (wb_adr),
  .wb_dat_o  (wb_dat_o),
  .wb_ack    (wb_ack)
);

// File: tb/sim_jtag_dbg_bridge.sv
`timescale 1ns/1ps
module sim_jtag_dbg_bridge;

  logic clk = 1'b0, tck = 1'b0, rst = 1'b1;
  logic tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  logic dmi_req, dmi_we, dmi_ack;
  logic [7:0]  dmi_addr;
  logic [63:0] dmi_wdata, dmi_rdata;
  logic wb_cyc, wb_stb, wb_we, wb_ack;
  logic [63:0] wb_adr, wb_dat_o, wb_dat_i;

  always #5  clk = ~clk;
  always #20 tck = ~tck;

  jtag_dbg_bridge u0 (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .dmi_req(dmi_req), .dmi_we(dmi_we), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata),
    .dmi_rdata(dmi_rdata), .dmi_ack(dmi_ack),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // ---------------- bus target models ----------------
  logic [63:0] dmi_mem [0:255];
  logic [63:0] wb_mem  [0:15];
  int dcnt, wcnt;
  int dmi_wr_n, wb_wr_n;
  logic [7:0]  dmi_last_a;
  logic [63:0] dmi_last_d, wb_last_a, wb_last_d;

  always @(posedge clk) begin
    if (rst) begin
      dmi_ack <= 1'b0; dcnt <= 0; dmi_rdata <= '0; dmi_wr_n <= 0;
      dmi_last_a <= '0; dmi_last_d <= '0;
      for (int i = 0; i < 256; i++) dmi_mem[i] <= 64'h0123_4567_0000_0000 + 64'(i);
    end else if (dmi_req && !dmi_ack) begin
      if (dcnt == 2) begin
        dcnt <= 0; dmi_ack <= 1'b1; dmi_rdata <= dmi_mem[dmi_addr];
        if (dmi_we) begin
          dmi_mem[dmi_addr] <= dmi_wdata; dmi_wr_n <= dmi_wr_n + 1;
          dmi_last_a <= dmi_addr; dmi_last_d <= dmi_wdata;
        end
      end else dcnt <= dcnt + 1;
    end else dmi_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst) begin
      wb_ack <= 1'b0; wcnt <= 0; wb_dat_i <= '0; wb_wr_n <= 0;
      wb_last_a <= '0; wb_last_d <= '0;
      for (int i = 0; i < 16; i++) wb_mem[i] <= 64'hFACE_0000_0000_0000 + 64'(i * 16);
    end else if (wb_cyc && wb_stb && !wb_ack) begin
      if (wcnt == 3) begin
        wcnt <= 0; wb_ack <= 1'b1; wb_dat_i <= wb_mem[wb_adr[3:0]];
        if (wb_we) begin
          wb_mem[wb_adr[3:0]] <= wb_dat_o; wb_wr_n <= wb_wr_n + 1;
          wb_last_a <= wb_adr; wb_last_d <= wb_dat_o;
        end
      end else wcnt <= wcnt + 1;
    end else wb_ack <= 1'b0;
  end

  // ---------------- monitors ----------------
  int drop_err = 0, glitch = 0, oe_bad = 0;
  logic p_dreq = 0, p_dack = 0, p_wreq = 0, p_wack = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_dreq && !p_dack && !dmi_req) drop_err++;
      if (p_wreq && !p_wack && !wb_cyc)  drop_err++;
    end
    p_dreq = dmi_req; p_dack = dmi_ack; p_wreq = wb_cyc; p_wack = wb_ack;
  end
  always @(posedge tck) begin
    logic t0, o0;
    t0 = tdo; o0 = tdo_oe;
    #1;
    if (tdo !== t0 || tdo_oe !== o0) glitch++;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic ms, input logic di, output logic dout);
    @(negedge tck); #2;
    tms = ms; tdi = di;
    #10;
    dout = tdo;
    @(posedge tck);
  endtask

  task automatic idle(input int n);
    logic d;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, d);
      if (i > 1 && tdo_oe !== 1'b0) oe_bad++;
    end
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic d;
    step(1'b1, 1'b0, d); step(1'b1, 1'b0, d); step(1'b0, 1'b0, d); step(1'b0, 1'b0, d);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], d);
      cap[i] = d;
      if (tdo_oe !== 1'b1) oe_bad++;
    end
    step(1'b1, 1'b0, d); step(1'b0, 1'b0, d);
  endtask

  task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic d;
    dout = '0;
    step(1'b1, 1'b0, d); step(1'b0, 1'b0, d); step(1'b0, 1'b0, d);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], d);
      dout[i] = d;
      if (tdo_oe !== 1'b1) oe_bad++;
    end
    step(1'b1, 1'b0, d); step(1'b0, 1'b0, d);
    idle(12);
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [3:0]  ir;
    logic [7:0]  len;
    logic [63:0] din;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  8'd32, 64'h0,    64'h0000_0000_0000_18FF, 8'd1}, // R1 id by instruction
    '{4'd8,  8'd8,  64'h03,   64'h00,                  8'd4}, // R4 capture old address
    '{4'd8,  8'd8,  64'h03,   64'h03,                  8'd4}, // R4 address readback
    '{4'd9,  8'd64, 64'h0,    64'h0123_4567_0000_0003, 8'd5}, // R5 read
    '{4'd10, 8'd64, 64'hA5,   64'h0123_4567_0000_0003, 8'd6}, // R6 old value
    '{4'd9,  8'd64, 64'h0,    64'h0000_0000_0000_00A5, 8'd6}, // R6 new value
    '{4'd5,  8'd64, 64'h2,    64'h0,                   8'd7}, // R7 address
    '{4'd6,  8'd64, 64'h0,    64'hFACE_0000_0000_0020, 8'd7}, // R7 read
    '{4'd7,  8'd64, 64'hFEEF, 64'hFACE_0000_0000_0020, 8'd7}, // R7 old value
    '{4'd6,  8'd64, 64'h0,    64'h0000_0000_0000_FEEF, 8'd7}, // R7 new value
    '{4'd8,  8'd8,  64'h10,   64'h03,                  8'd4}, // R4 move address
    '{4'd9,  8'd64, 64'h0,    64'h0123_4567_0000_0010, 8'd5}, // R5 prefetch follows address
    '{4'd5,  8'd64, 64'h2,    64'h2,                   8'd7}  // R7 address readback
  };

  initial begin
    logic [3:0]  ic;
    logic [63:0] dv;
    repeat (10) @(posedge tck);
    @(negedge tck); rst = 1'b0;
    #3;
    // R10 reset state
    check("R10 tdo_oe", 64'(tdo_oe), 64'h0);
    check("R10 dmi_req", 64'(dmi_req), 64'h0);
    check("R10 wb_cyc", 64'(wb_cyc), 64'h0);
    idle(3);
    scan_dr(32, 64'h0, dv);
    check("R10 id after reset", dv, 64'h18FF);

    for (int v = 0; v < NV; v++) begin
      scan_ir(VEC[v].ir, ic);
      if (v == 0) check("R2 ir capture", 64'(ic), 64'h1);
      scan_dr(int'(VEC[v].len), VEC[v].din, dv);
      checks++;
      if (dv !== VEC[v].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", VEC[v].req, v, dv, VEC[v].exp);
      end
    end

    // R6 and R7 write side effects
    check("R6 write count", 64'(dmi_wr_n), 64'd1);
    check("R6 write addr", 64'(dmi_last_a), 64'h03);
    check("R6 write data", dmi_last_d, 64'hA5);
    check("R7 write count", 64'(wb_wr_n), 64'd1);
    check("R7 write addr", wb_last_a, 64'h2);
    check("R7 write data", wb_last_d, 64'hFEEF);

    // R3 bypass with unused code
    scan_ir(4'hC, ic);
    check("R2 ir capture again", 64'(ic), 64'h1);
    scan_dr(8, 64'hB3, dv);
    check("R3 bypass delay", dv, 64'h66);

    // R1 TMS reset from another instruction
    scan_ir(4'd8, ic);
    begin
      logic d;
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, d);
    end
    idle(2);
    scan_dr(32, 64'h0, dv);
    check("R1 id after tms reset", dv, 64'h18FF);

    // R8 / R9 monitors
    check("R8 request dropped early", 64'(drop_err), 64'd0);
    check("R9 tdo edge", 64'(glitch), 64'd0);
    check("R9 tdo_oe state", 64'(oe_bad), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule